// File: doc/BRIEF.md
# Snooping Invalidation Coherence Controller

This block is the coherence agent for one small, direct-mapped, write-back cache that shares a snooping bus with other caches. Each line carries a tag, a word of data and a coherence state: Invalid, Shared (readable, clean) or Exclusive (the only copy, writable, dirty). The state is kept as a valid bit plus a dirty bit. Exclusive is valid with dirty set, and Shared is valid with dirty clear. The state changes in response to local CPU accesses and to transactions that other caches place on the bus.

A CPU access that can complete locally is answered in the same cycle. An access that needs the bus first issues a request: a write-back of a dirty victim if needed, then a read miss or a write miss. Once that request is granted the line is installed, and the access then completes as a hit. The bus grant is the only ordering point. In parallel, every snooped address is looked up. If the line is held Exclusive, its data is driven out so that the requester and memory see the latest value. The line is then demoted to Shared on a snooped read miss, or invalidated on a snooped write miss.

Addresses split into a line index (the low log2(LINES) bits) and a tag (the remaining upper bits). Bus command codes are 0 for none, 1 for read miss, 2 for write miss and 3 for write-back.

Top module: `snoopCohCtrl`

## Requirements
- R1: After reset every line is Invalid. With no CPU request and no snoop, busReqValid, cpuReady and snpSupply are all low.
- R2: A CPU read whose tag matches a valid line (Shared or Exclusive) raises cpuReady in the same cycle with the line data on cpuRdata, and makes no bus request.
- R3: A CPU read miss drives busReqValid with busReqCmd=1 and the CPU address until a grant. On the grant the line is installed Shared with busFillData, and the read completes in the next cycle.
- R4: A CPU write miss drives busReqCmd=2. On the grant the line is installed Exclusive, and the write completes in the next cycle.
- R5: A CPU write that hits a Shared line issues busReqCmd=2 as an upgrade. busFillData is ignored, the line becomes Exclusive, and then the write data is stored.
- R6: A CPU write that hits an Exclusive line stores the data in the same cycle with cpuReady high and makes no bus request.
- R7: A snooped read miss (snpCmd=1) to an Exclusive line raises snpSupply in that cycle with the line data on snpData, and leaves the line Shared. A second snoop of the same line gets no supply, and a later CPU write needs an upgrade.
- R8: A snooped write miss (snpCmd=2) to a valid matching line invalidates it, raising snpSupply with the data if the line was Exclusive. A later CPU read of that line misses.
- R9: A snoop whose tag does not match, or which reads a Shared line, raises no supply and changes no state.
- R10: A miss whose index holds an Exclusive line with another tag first drives busReqCmd=3, with the victim address ({victim tag, index}) and the victim data. After that grant it issues the miss. If a snooped write miss takes the victim's dirtiness away first, the write-back is skipped.
- R11: cpuReady stays low while a bus request of the access is outstanding. In any cycle with snpValid high the CPU access is held and a bus grant is ignored, so the snoop acts first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | CPU access request, held until cpuReady |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | CPU word address |
| cpuWdata | input | DATA_W | CPU write data |
| cpuReady | output | 1 | Access completes in this cycle |
| cpuRdata | output | DATA_W | Read data, valid with cpuReady |
| busReqValid | output | 1 | Bus request pending |
| busReqCmd | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| busReqAddr | output | ADDR_W | Request address |
| busReqData | output | DATA_W | Write-back data |
| busGrant | input | 1 | Request granted and completed this cycle |
| busFillData | input | DATA_W | Fill data returned with a miss grant |
| snpValid | input | 1 | Snooped transaction present |
| snpCmd | input | 2 | 1 read miss, 2 write miss |
| snpAddr | input | ADDR_W | Snooped address |
| snpSupply | output | 1 | This cache supplies dirty data |
| snpData | output | DATA_W | Supplied data |

## Verification
A wrong coherence state does not stay hidden. A line left Exclusive after a snooped read shows up as a second supply on the next snoop, or as a missing upgrade request on the next CPU write. A line left valid after a snooped write miss answers a later read as a hit instead of issuing a bus read. A dirty bit lost too early drops the write-back ahead of a conflicting miss. Each of these appears at the ports in the first cycle that probes the line, and the bench compares every output against its own model on every clock.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_RDMISS = 2'd1,
    CMD_WRMISS = 2'd2,
    CMD_WBACK  = 2'd3
  } busCmd_e;

  typedef struct packed {
    logic writeHit;
    logic install;
    logic installDirty;
    logic keepData;
    logic wbDone;
  } ctlStrobe_t;

  typedef struct packed {
    logic hit;
    logic exclHit;
    logic victimDirty;
  } lookup_t;
endpackage

// File: rtl/coh_datapath.sv
module coh_datapath
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] fillData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output lookup_t           look,
  output logic [DATA_W-1:0] lineData,
  output logic [ADDR_W-1:0] victimAddr,
  output logic              snpSupply,
  output logic [DATA_W-1:0] snpData
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0]  tagQ   [LINES];
  logic [DATA_W-1:0] dataQ  [LINES];
  logic              validQ [LINES];
  logic              dirtyQ [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  logic             snpHit;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  always_comb begin
    look.hit         = validQ[cpuIdx] && (tagQ[cpuIdx] == cpuTag);
    look.exclHit     = look.hit && dirtyQ[cpuIdx];
    look.victimDirty = validQ[cpuIdx] && dirtyQ[cpuIdx] && (tagQ[cpuIdx] != cpuTag);
  end

  assign lineData   = dataQ[cpuIdx];
  assign victimAddr = {tagQ[cpuIdx], cpuIdx};

  assign snpHit    = validQ[snpIdx] && (tagQ[snpIdx] == snpTag);
  assign snpSupply = snpValid && snpHit && dirtyQ[snpIdx];
  assign snpData   = dataQ[snpIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        validQ[i] <= 1'b0;
        dirtyQ[i] <= 1'b0;
        tagQ[i]   <= '0;
        dataQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (snpValid && snpHit && (snpIdx == IDX_W'(i))) begin
          if (snpCmd == CMD_WRMISS) begin
            validQ[i] <= 1'b0;
            dirtyQ[i] <= 1'b0;
          end else if (snpCmd == CMD_RDMISS) begin
            dirtyQ[i] <= 1'b0;
          end
        end else if (cpuIdx == IDX_W'(i)) begin
          if (strobe.writeHit) begin
            dataQ[i] <= cpuWdata;
          end else if (strobe.install) begin
            tagQ[i]   <= cpuTag;
            validQ[i] <= 1'b1;
            dirtyQ[i] <= strobe.installDirty;
            if (!strobe.keepData) dataQ[i] <= fillData;
          end else if (strobe.wbDone) begin
            validQ[i] <= 1'b0;
            dirtyQ[i] <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/coh_control.sv
module coh_control
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  lookup_t           look,
  input  logic              snpValid,
  input  logic              busGrant,
  input  logic [ADDR_W-1:0] victimAddr,
  output ctlStrobe_t        strobe,
  output logic              cpuReady,
  output logic              busReqValid,
  output logic [1:0]        busReqCmd,
  output logic [ADDR_W-1:0] busReqAddr
);
  typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_MISS} ctlState_e;
  ctlState_e stateQ, stateD;
  busCmd_e   cmd;
  logic      granted;

  assign granted = busGrant && !snpValid;

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    cpuReady    = 1'b0;
    busReqValid = 1'b0;
    cmd         = CMD_NONE;
    busReqAddr  = cpuAddr;
    case (stateQ)
      ST_IDLE: begin
        if (cpuReq && !snpValid) begin
          if (look.hit && (!cpuWe || look.exclHit)) begin
            cpuReady        = 1'b1;
            strobe.writeHit = cpuWe;
          end else begin
            stateD = look.victimDirty ? ST_WBACK : ST_MISS;
          end
        end
      end
      ST_WBACK: begin
        busReqValid = look.victimDirty;
        cmd         = CMD_WBACK;
        busReqAddr  = victimAddr;
        if (!look.victimDirty) begin
          stateD = ST_MISS;
        end else if (granted) begin
          strobe.wbDone = 1'b1;
          stateD        = ST_MISS;
        end
      end
      ST_MISS: begin
        busReqValid = 1'b1;
        cmd         = cpuWe ? CMD_WRMISS : CMD_RDMISS;
        if (granted) begin
          strobe.install      = 1'b1;
          strobe.installDirty = cpuWe;
          strobe.keepData     = look.hit;
          stateD              = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busReqCmd = cmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/snoopCohCtrl.sv
module snoopCohCtrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReqValid,
  output logic [1:0]        busReqCmd,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [DATA_W-1:0] busReqData,
  input  logic              busGrant,
  input  logic [DATA_W-1:0] busFillData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpSupply,
  output logic [DATA_W-1:0] snpData
);
  ctlStrobe_t        strobe;
  lookup_t           look;
  logic [DATA_W-1:0] lineData;
  logic [ADDR_W-1:0] victimAddr;

  coh_control #(.ADDR_W(ADDR_W)) ctl_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .look(look), .snpValid(snpValid), .busGrant(busGrant), .victimAddr(victimAddr),
    .strobe(strobe), .cpuReady(cpuReady), .busReqValid(busReqValid),
    .busReqCmd(busReqCmd), .busReqAddr(busReqAddr)
  );

  coh_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .fillData(busFillData), .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .look(look), .lineData(lineData), .victimAddr(victimAddr),
    .snpSupply(snpSupply), .snpData(snpData)
  );

  assign cpuRdata   = lineData;
  assign busReqData = lineData;
endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic              cpuReady,
  input logic              busReqValid,
  input logic [1:0]        busReqCmd,
  input logic              busGrant,
  input logic              snpValid,
  input logic [1:0]        snpCmd,
  input logic [ADDR_W-1:0] snpAddr,
  input logic              snpSupply
);
  p_ready_no_bus_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !busReqValid);

  p_ready_needs_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> (cpuReq && !snpValid));

  p_supply_needs_snoop_r7: assert property (@(posedge clk) disable iff (!rstN)
    snpSupply |-> snpValid);

  p_cmd_defined_r3: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> (busReqCmd != 2'd0));

  p_miss_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busReqCmd != 2'd3 && !busGrant) |=> busReqValid);

  p_fill_then_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busGrant && !snpValid && busReqCmd == 2'd1 && !cpuWe)
      |=> (!cpuReq || snpValid || cpuReady));

  p_wb_then_miss_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busGrant && !snpValid && busReqCmd == 2'd3)
      |=> (busReqValid && busReqCmd != 2'd3));

  p_demoted_no_resupply_r7: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpCmd == 2'd1 && snpSupply)
      |=> !(snpValid && $stable(snpAddr) && snpSupply));

  p_invalidated_no_supply_r8: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpCmd == 2'd2 && snpSupply)
      |=> !(snpValid && $stable(snpAddr) && snpSupply));
endmodule

bind snoopCohCtrl coh_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuReady(cpuReady),
  .busReqValid(busReqValid), .busReqCmd(busReqCmd), .busGrant(busGrant),
  .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr), .snpSupply(snpSupply)
);

// File: tb/snoopCohCtrl_tb_top.sv
`timescale 1ns/1ps
module snoopCohCtrl_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int LINES  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic              cpuReq = 0, cpuWe = 0, busGrant = 0, snpValid = 0;
  logic [ADDR_W-1:0] cpuAddr = 0, snpAddr = 0;
  logic [DATA_W-1:0] cpuWdata = 0, busFillData = 0;
  logic [1:0]        snpCmd = 0;
  logic              cpuReady, busReqValid, snpSupply;
  logic [DATA_W-1:0] cpuRdata, busReqData, snpData;
  logic [1:0]        busReqCmd;
  logic [ADDR_W-1:0] busReqAddr;

  snoopCohCtrl dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .busReqValid(busReqValid), .busReqCmd(busReqCmd), .busReqAddr(busReqAddr),
    .busReqData(busReqData), .busGrant(busGrant), .busFillData(busFillData),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpSupply(snpSupply), .snpData(snpData)
  );

  int checks = 0;
  int errors = 0;

  // staged stimulus, applied at the falling edge
  bit sReq, sWe, sGrant, sSv;
  int sAddr, sWdata, sFill, sScmd, sSaddr;

  // behavioural reference model
  bit mV[LINES];
  bit mD[LINES];
  int mTag[LINES];
  int mData[LINES];
  int phase;            // 0 idle, 1 write-back pending, 2 miss pending
  bit lastReady;

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic bit predictBv();
    int idx = sAddr % LINES;
    int tg  = sAddr / LINES;
    bit vd  = mV[idx] && mD[idx] && (mTag[idx] != tg);
    if (phase == 1) return vd;
    if (phase == 2) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(string tag);
    int idx, tg, sidx, stg;
    bit hit, excl, vd, shit, eReady, eBv, eSup;
    int eCmd, eAddr;
    @(negedge clk);
    cpuReq = sReq; cpuWe = sWe; cpuAddr = sAddr[ADDR_W-1:0];
    cpuWdata = sWdata[DATA_W-1:0]; busGrant = sGrant; busFillData = sFill[DATA_W-1:0];
    snpValid = sSv; snpCmd = sScmd[1:0]; snpAddr = sSaddr[ADDR_W-1:0];
    #1;
    idx = sAddr % LINES; tg = sAddr / LINES;
    hit = mV[idx] && mTag[idx] == tg;
    excl = hit && mD[idx];
    vd = mV[idx] && mD[idx] && mTag[idx] != tg;
    eReady = (phase == 0) && sReq && !sSv && hit && (!sWe || excl);
    eBv = 0; eCmd = 0; eAddr = sAddr;
    if (phase == 1) begin eBv = vd; eCmd = 3; eAddr = mTag[idx] * LINES + idx; end
    if (phase == 2) begin eBv = 1; eCmd = sWe ? 2 : 1; end
    sidx = sSaddr % LINES; stg = sSaddr / LINES;
    shit = mV[sidx] && mTag[sidx] == stg;
    eSup = sSv && shit && mD[sidx];

    check(tag, "cpuReady", int'(cpuReady), int'(eReady));
    if (eReady && !sWe) check(tag, "cpuRdata", int'(cpuRdata), mData[idx]);
    check(tag, "busReqValid", int'(busReqValid), int'(eBv));
    if (eBv) begin
      check(tag, "busReqCmd", int'(busReqCmd), eCmd);
      check(tag, "busReqAddr", int'(busReqAddr), eAddr);
      if (eCmd == 3) check(tag, "busReqData", int'(busReqData), mData[idx]);
    end
    check(tag, "snpSupply", int'(snpSupply), int'(eSup));
    if (eSup) check(tag, "snpData", int'(snpData), mData[sidx]);
    lastReady = eReady;

    // next model state
    if (sSv && shit) begin
      if (sScmd == 2) begin mV[sidx] = 0; mD[sidx] = 0; end
      else if (sScmd == 1) mD[sidx] = 0;
    end
    case (phase)
      0: if (sReq && !sSv) begin
           if (eReady) begin if (sWe) mData[idx] = sWdata; end
           else phase = vd ? 1 : 2;
         end
      1: if (!vd) phase = 2;
         else if (sGrant && !sSv) begin mV[idx] = 0; mD[idx] = 0; phase = 2; end
      default: if (sGrant && !sSv) begin
           if (!hit) mData[idx] = sFill;
           mTag[idx] = tg; mV[idx] = 1; mD[idx] = sWe; phase = 0;
         end
    endcase
  endtask

  task automatic cpuOp(string tag, bit we, int addr, int wdata, int fill,
                       int delay, int snpAt, int scmd, int saddr);
    int cnt = 0;
    bit done = 0;
    sReq = 1; sWe = we; sAddr = addr; sWdata = wdata; sFill = fill;
    for (int k = 0; k < 60 && !done; k++) begin
      bit bv;
      sSv = (k == snpAt); sScmd = scmd; sSaddr = saddr;
      bv = predictBv();
      sGrant = bv && (cnt >= delay);
      if (bv) cnt++; else cnt = 0;
      step(tag);
      done = lastReady;
    end
    sReq = 0; sGrant = 0; sSv = 0;
    if (!done) check(tag, "access completion", 0, 1);
  endtask

  task automatic snoopOp(string tag, int scmd, int saddr);
    sSv = 1; sScmd = scmd; sSaddr = saddr;
    step(tag);
    sSv = 0;
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin mV[i] = 0; mD[i] = 0; mTag[i] = 0; mData[i] = 0; end
    phase = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step("R1"); step("R1");
    cpuOp("R3", 0, 'h05, 0, 'hA5, 2, -1, 0, 0);        // read miss, install Shared
    cpuOp("R2", 0, 'h05, 0, 0, 0, -1, 0, 0);           // read hit on Shared
    cpuOp("R5", 1, 'h05, 'h11, 'hEE, 1, -1, 0, 0);     // upgrade, fill ignored
    cpuOp("R2", 0, 'h05, 0, 0, 0, -1, 0, 0);           // read back 11
    cpuOp("R6", 1, 'h05, 'h22, 0, 0, -1, 0, 0);        // write hit Exclusive
    snoopOp("R7", 1, 'h05);                            // supply 22, demote
    snoopOp("R9", 1, 'h05);                            // Shared, no supply
    cpuOp("R7", 1, 'h05, 'h33, 0, 0, -1, 0, 0);        // needs upgrade again
    snoopOp("R9", 2, 'h45);                            // other tag, ignored
    cpuOp("R9", 0, 'h05, 0, 0, 0, -1, 0, 0);           // still hit with 33
    snoopOp("R8", 2, 'h05);                            // supply 33, invalidate
    cpuOp("R8", 0, 'h05, 0, 'h5A, 0, -1, 0, 0);        // now misses
    cpuOp("R4", 1, 'h06, 'h77, 'h60, 3, -1, 0, 0);     // write miss
    cpuOp("R10", 0, 'h0A, 0, 'hB0, 1, -1, 0, 0);       // write-back of 06 then read miss
    cpuOp("R10", 1, 'h0E, 'h44, 'hC0, 0, -1, 0, 0);    // write miss into Shared-victim index
    cpuOp("R10", 0, 'h12, 0, 'hD0, 3, 1, 2, 'h0E);     // snoop steals victim: no write-back
    cpuOp("R11", 0, 'h07, 0, 'hE7, 1, 2, 1, 'h33);     // grant during snoop ignored
    cpuOp("R11", 0, 'h07, 0, 0, 0, 0, 1, 'h20);        // hit held by snoop cycle
    cpuOp("R4", 1, 'h03, 'h99, 'h30, 0, -1, 0, 0);
    snoopOp("R8", 2, 'h03);
    cpuOp("R3", 0, 'h03, 0, 'h3C, 4, -1, 0, 0);
    step("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule